// File: doc/BRIEF.md
# Banked Row/Column Strobe Sequencer with Per-Bank Precharge

This block drives the row strobes (one per bank) and four column strobes for a dynamic memory array that is organised as one, two or four banks, up to 32 bits wide. A one-cycle start pulse selects a target bank through a two-bit bank select and supplies four active-low byte-lane enables. The block first pulls the row strobe of the target bank group low. After a programmable row-to-column delay it drives the column strobes of the enabled byte lanes low. After a programmable column hold time it releases every strobe on the same edge. Each row strobe then has to stay high for a programmed precharge time.

Every bank has its own precharge counter, so an access to a different bank can begin on the cycle after the previous access ends. A start that targets a bank that is still precharging is held inside the block and launches as soon as that bank is free. A per-bank ready output shows which banks would accept a launch. Address multiplexing and arbitration between requesters are handled outside the block.

Top module: `ras_cas_ctrl`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are all ones and `bank_rdy` is all ones.
- R2: The bank group follows `cfg_org`. With 2'b00, all four row strobes act together. With 2'b01, only `bank_sel[0]` is decoded: a value of 0 drives rows 0 and 2, and a value of 1 drives rows 1 and 3. With 2'b10 or 2'b11, only row `bank_sel` is driven.
- R3: A start that is accepted at a clock edge while its group is free drives the group's row strobes low after that edge. The column strobes fall exactly max(`cfg_rcd`,1) cycles later.
- R4: The column strobes stay low for exactly max(`cfg_cas`,1) cycles. Then the row and column strobes all return high on the same edge.
- R5: During the column phase, `cas_n[i]` is low exactly when `byte_en_n[i]` was 0 at the accepting edge, so `cas_n` equals the captured `byte_en_n`. Later changes of `byte_en_n` have no effect, and an all-ones value leaves every column strobe high.
- R6: When a group's row strobes return high, `bank_rdy` of those banks is low for exactly `cfg_pre` cycles (the value at that edge) and then returns high. Banks outside the group keep their own status.
- R7: A start whose group is not yet free is held. Its row strobes fall after the first edge at which every bank in the group shows ready, so each row strobe stays high for at least `cfg_pre`+1 cycles.
- R8: A start to a different, ready bank, sampled on the edge right after the previous access ends, launches on that edge with no added cycles.
- R9: A start that arrives while an access is in progress or while a held start is pending is ignored.
- R10: `bank_rdy[i]` is low whenever `ras_n[i]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle access request |
| bank_sel | input | 2 | Target bank select |
| byte_en_n | input | 4 | Active-low byte-lane enables |
| cfg_org | input | 2 | Array organisation: one, two or four banks |
| cfg_rcd | input | DLY_W | Row-to-column delay in cycles (0 acts as 1) |
| cfg_cas | input | DLY_W | Column strobe length in cycles (0 acts as 1) |
| cfg_pre | input | PRE_W | Precharge time in cycles |
| ras_n | output | 4 | Active-low row strobe per bank |
| cas_n | output | 4 | Active-low column strobe per byte lane |
| bank_rdy | output | 4 | Bank is idle and has finished precharge |

## Verification
All outputs are registered. Row strobes change one edge after the accepting edge, column strobes fall max(`cfg_rcd`,1) edges later and rise max(`cfg_cas`,1) edges after that, and ready returns `cfg_pre` edges after the release. The bench drives inputs on the falling clock edge and reads outputs on the following falling edge. It keeps an edge counter and records, for each bank, the first edge at which that bank may launch again. From these records it computes the expected launch edge of a held start and the expected `bank_rdy` value on every cycle, and compares them with the outputs in every cycle of every access.

// File: rtl/ras_cas_pkg.sv
package ras_cas_pkg;

    localparam int BANKS = 4;
    localparam int LANES = 4;
    localparam int SEL_W = $clog2(BANKS);

    typedef enum logic [1:0] {
        ORG_ONE  = 2'b00,
        ORG_TWO  = 2'b01,
        ORG_FOUR = 2'b10,
        ORG_ALT  = 2'b11
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_RCD  = 2'b10,
        ST_CAS  = 2'b11
    } seq_state_e;

endpackage

// File: rtl/ras_cas_bank_decode.sv
module ras_cas_bank_decode
    import ras_cas_pkg::*;
(
    input  logic [1:0]       org,
    input  logic [SEL_W-1:0] sel,
    output logic [BANKS-1:0] grp
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb begin
            case (org)
                ORG_ONE: grp[b] = 1'b1;
                ORG_TWO: grp[b] = (sel[0] == 1'(b % 2));
                default: grp[b] = (sel == SEL_W'(b));
            endcase
        end
    end

endmodule

// File: rtl/ras_cas_pre_timer.sv
module ras_cas_pre_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/ras_cas_ctrl.sv
module ras_cas_ctrl
    import ras_cas_pkg::*;
#(
    parameter int DLY_W = 4,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       bank_sel,
    input  logic [3:0]       byte_en_n,
    input  logic [1:0]       cfg_org,
    input  logic [DLY_W-1:0] cfg_rcd,
    input  logic [DLY_W-1:0] cfg_cas,
    input  logic [PRE_W-1:0] cfg_pre,
    output logic [3:0]       ras_n,
    output logic [3:0]       cas_n,
    output logic [3:0]       bank_rdy
);

    typedef struct packed {
        seq_state_e       st;
        logic [BANKS-1:0] grp;
        logic [LANES-1:0] lane_n;
        logic [DLY_W-1:0] tmr;
        logic [BANKS-1:0] ras_act;
        logic [LANES-1:0] cas_n;
    } seq_t;

    seq_t             s_d, s_q;
    logic [BANKS-1:0] req_grp;
    logic [BANKS-1:0] pre_done;
    logic [BANKS-1:0] pre_load;
    logic [BANKS-1:0] launch_grp;
    logic             do_launch;
    logic             req_free, pend_free;
    logic [DLY_W-1:0] rcd_last, cas_last;

    ras_cas_bank_decode u_decode (
        .org (cfg_org),
        .sel (bank_sel),
        .grp (req_grp)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_pre
        ras_cas_pre_timer #(.CNT_W(PRE_W)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (pre_load[b]),
            .load_val (cfg_pre),
            .done     (pre_done[b])
        );
    end

    assign req_free  = &(pre_done | ~req_grp);
    assign pend_free = &(pre_done | ~s_q.grp);
    assign rcd_last  = (cfg_rcd == '0) ? '0 : cfg_rcd - 1'b1;
    assign cas_last  = (cfg_cas == '0) ? '0 : cfg_cas - 1'b1;

    always_comb begin
        s_d        = s_q;
        pre_load   = '0;
        do_launch  = 1'b0;
        launch_grp = s_q.grp;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.grp    = req_grp;
                    s_d.lane_n = byte_en_n;
                    launch_grp = req_grp;
                    if (req_free) begin
                        do_launch = 1'b1;
                    end else begin
                        s_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (pend_free) begin
                    do_launch = 1'b1;
                end
            end
            ST_RCD: begin
                if (s_q.tmr == '0) begin
                    s_d.st    = ST_CAS;
                    s_d.cas_n = s_q.lane_n;
                    s_d.tmr   = cas_last;
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            ST_CAS: begin
                if (s_q.tmr == '0) begin
                    s_d.st      = ST_IDLE;
                    s_d.ras_act = '0;
                    s_d.cas_n   = '1;
                    pre_load    = s_q.grp;
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (do_launch) begin
            s_d.st      = ST_RCD;
            s_d.ras_act = launch_grp;
            s_d.tmr     = rcd_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ST_IDLE;
            s_q.grp     <= '0;
            s_q.lane_n  <= '1;
            s_q.tmr     <= '0;
            s_q.ras_act <= '0;
            s_q.cas_n   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n    = ~s_q.ras_act;
    assign cas_n    = s_q.cas_n;
    assign bank_rdy = pre_done & ~s_q.ras_act;

endmodule

// File: rtl/ras_cas_ctrl_chk.sv
module ras_cas_ctrl_chk #(
    parameter int PRE_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_org,
    input logic [PRE_W-1:0] cfg_pre,
    input logic [3:0]       ras_n,
    input logic [3:0]       cas_n,
    input logic [3:0]       bank_rdy
);

    // R3: a column strobe is only ever low under an active row
    p_cas_under_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != 4'hF) |-> (ras_n != 4'hF));

    // R2: row strobe pattern matches the organisation
    p_grp_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_org == 2'b00) ? (ras_n == 4'h0 || ras_n == 4'hF) :
        (cfg_org == 2'b01) ? (ras_n == 4'hF || ras_n == 4'h5 || ras_n == 4'hA) :
        $onehot0(~ras_n));

    // R4: column strobes are released no later than the row strobes
    p_release_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(ras_n) & ras_n)) |-> (cas_n == 4'hF));

    // R5: the column pattern cannot change while any lane is active
    p_cas_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != 4'hF && $past(cas_n) != 4'hF) |-> $stable(cas_n));

    // R7: a row strobe only falls on a bank that was ready
    p_launch_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ras_n) & ~ras_n & ~$past(bank_rdy)) == 4'h0));

    // R10: an active bank never reports ready
    p_rdy_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ras_n & bank_rdy) == 4'h0));

    // R6: nonzero precharge makes released banks not ready
    p_pre_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(~$past(ras_n) & ras_n)) && ($past(cfg_pre) != '0))
        |-> ((bank_rdy & ~$past(ras_n) & ras_n) == 4'h0));

endmodule

bind ras_cas_ctrl ras_cas_ctrl_chk #(.PRE_W(PRE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_org  (cfg_org),
    .cfg_pre  (cfg_pre),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .bank_rdy (bank_rdy)
);

// File: tb/ras_cas_ctrl_tb.sv
`timescale 1ns/1ps
module ras_cas_ctrl_tb;

    localparam int DLY_W = 4;
    localparam int PRE_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       bank_sel = '0;
    logic [3:0]       byte_en_n = '1;
    logic [1:0]       cfg_org = 2'b10;
    logic [DLY_W-1:0] cfg_rcd = 4'd2;
    logic [DLY_W-1:0] cfg_cas = 4'd3;
    logic [PRE_W-1:0] cfg_pre = 5'd4;
    logic [3:0]       ras_n, cas_n, bank_rdy;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int ready_edge [4] = '{0, 0, 0, 0};

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ras_cas_ctrl #(.DLY_W(DLY_W), .PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bank_sel(bank_sel),
        .byte_en_n(byte_en_n), .cfg_org(cfg_org), .cfg_rcd(cfg_rcd),
        .cfg_cas(cfg_cas), .cfg_pre(cfg_pre), .ras_n(ras_n),
        .cas_n(cas_n), .bank_rdy(bank_rdy)
    );

    function automatic logic [3:0] f_mask(input logic [1:0] org, input logic [1:0] sel);
        if (org == 2'b00) return 4'hF;
        if (org == 2'b01) return sel[0] ? 4'hA : 4'h5;
        return 4'(1 << sel);
    endfunction

    function automatic logic [3:0] f_exp_rdy(input logic [3:0] act);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = !act[i] && (cyc >= ready_edge[i] - 1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_rdy(input logic [3:0] act, input string req);
        logic [3:0] e;
        e = f_exp_rdy(act);
        chk(bank_rdy == e, req, bank_rdy, e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            tick();
            chk(ras_n == 4'hF && cas_n == 4'hF, "R9 idle strobes", {ras_n, cas_n}, 8'hFF);
            chk_rdy(4'h0, "R6 idle ready");
        end
    endtask

    task automatic access(input logic [1:0] sel, input logic [3:0] ben, input bit inject);
        logic [3:0] m;
        int s, exp_l, guard, rcd_e, cas_e;
        m     = f_mask(cfg_org, sel);
        rcd_e = (cfg_rcd == 0) ? 1 : int'(cfg_rcd);
        cas_e = (cfg_cas == 0) ? 1 : int'(cfg_cas);
        start = 1'b1; bank_sel = sel; byte_en_n = ben;
        s = cyc + 1;
        exp_l = s;
        for (int i = 0; i < 4; i++) if (m[i] && ready_edge[i] > exp_l) exp_l = ready_edge[i];
        tick();
        start = 1'b0; bank_sel = 2'($urandom); byte_en_n = 4'($urandom);
        guard = 0;
        while (ras_n == 4'hF && guard < 200) begin
            chk(cas_n == 4'hF, "R7 held no column", cas_n, 4'hF);
            chk_rdy(4'h0, "R7 held ready");
            tick();
            guard++;
        end
        chk(cyc == exp_l, (exp_l > s) ? "R7 held launch edge" : "R8 launch edge", cyc, exp_l);
        chk(ras_n == ~m, "R2 row group", ras_n, ~m);
        chk(cas_n == 4'hF, "R3 column after row", cas_n, 4'hF);
        chk_rdy(m, "R10 ready while active");
        if (inject) begin
            start = 1'b1; bank_sel = ~sel; byte_en_n = 4'h0;
        end
        for (int k = 1; k < rcd_e; k++) begin
            tick();
            start = 1'b0;
            chk(ras_n == ~m && cas_n == 4'hF, "R3 row-to-column gap", {ras_n, cas_n}, {~m, 4'hF});
            chk_rdy(m, "R10 ready while active");
        end
        for (int k = 0; k < cas_e; k++) begin
            tick();
            start = 1'b0;
            chk(cas_n == ben, "R5 byte lanes", cas_n, ben);
            chk(ras_n == ~m, (k == 0) ? "R3 row held" : "R4 row held", ras_n, ~m);
            chk_rdy(m, "R10 ready while active");
        end
        tick();
        chk(ras_n == 4'hF && cas_n == 4'hF, "R4 joint release", {ras_n, cas_n}, 8'hFF);
        for (int i = 0; i < 4; i++) if (m[i]) ready_edge[i] = cyc + int'(cfg_pre) + 1;
        chk_rdy(4'h0, "R6 precharge ready");
        if (inject) begin
            idle(2);
            chk(ras_n == 4'hF, "R9 ignored start", ras_n, 4'hF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ras_n == 4'hF && cas_n == 4'hF, "R1 reset strobes", {ras_n, cas_n}, 8'hFF);
        chk(bank_rdy == 4'hF, "R1 reset ready", bank_rdy, 4'hF);
        rst_n = 1'b1;
        idle(1);

        // R3 R5 R8: four banks, interleaved back-to-back accesses
        access(2'd0, 4'h0, 1'b0);
        access(2'd1, 4'h5, 1'b0);
        // R7: return to a bank that is still precharging
        access(2'd1, 4'hA, 1'b0);
        // R6: let the precharge run out while idle
        idle(6);
        access(2'd3, 4'hF, 1'b0);
        // R9: start during an access is dropped
        access(2'd2, 4'h3, 1'b1);
        // R2: two-bank mode decodes only the low select bit
        idle(6);
        cfg_org = 2'b01;
        access(2'd3, 4'hE, 1'b0);
        access(2'd0, 4'h7, 1'b0);
        access(2'd2, 4'h0, 1'b0);
        // R2: one-bank mode drives all rows together
        idle(3);
        cfg_org = 2'b00;
        access(2'd1, 4'hC, 1'b0);
        access(2'd2, 4'h9, 1'b0);
        // R3 R4: zero delays behave as one cycle; zero precharge
        cfg_org = 2'b11; cfg_rcd = '0; cfg_cas = '0; cfg_pre = '0;
        access(2'd2, 4'h6, 1'b0);
        access(2'd2, 4'h1, 1'b1);

        for (int n = 0; n < 80; n++) begin
            idle(int'($urandom_range(0, 2)));
            if (($urandom & 3) == 0) cfg_org = 2'($urandom);
            cfg_rcd = DLY_W'($urandom_range(0, 4));
            cfg_cas = DLY_W'($urandom_range(0, 4));
            cfg_pre = PRE_W'($urandom_range(0, 7));
            access(2'($urandom), 4'($urandom), ($urandom_range(0, 7) == 0));
        end

        idle(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule